// File: doc/BRIEF.md
# Programmable Dead-Time Inserter

This block sits between a three-phase waveform generator and the gate drivers of a bridge. It receives six gate signals, a positive and a negative one for each phase, all active low, and holds every inactive-to-active transition back by a programmable number of count-source ticks. The leg's other switch therefore has time to turn off before this one turns on. Active-to-inactive transitions pass at once. Each of the six signals has its own counter, so the phases are delayed independently.

The dead time comes from an 8-bit write-only register that accepts 1 to 255. Ticks arrive on an enable input from an external prescaler. A mode input picks what starts the count. In one mode the input's own falling edge starts it. In the other mode the falling edge arms the channel and an external trigger pulse starts the count. A global disable input bypasses the whole delay path.

Top module: `dead_time_inserter`

## Requirements
- R1: During and after reset every output is 1 (inactive), and the dead-time register holds 1 until it is first written.
- R2: Active level is 0. With trig_sel=0, when gate_in[i] is sampled 0 at a clock edge after being 1, that edge starts channel i. gate_out[i] stays 1 until n ticks have been counted at later edges, and goes 0 right after the edge that samples the n-th tick. n is the dead-time value.
- R3: An input at 1 makes its output 1 in the same cycle, combinationally, with no delay.
- R4: If gate_in[i] returns to 1 before its count completes, the count is cancelled and gate_out[i] stays 1. A later fall restarts a full count.
- R5: With trig_sel=1, a fall only arms the channel. gate_out[i] stays 1, whatever cnt_tick does, until ext_trig is sampled 1. That edge starts the count as in R2.
- R6: With dt_off=1, gate_out equals gate_in combinationally. Clearing dt_off while an input is 0 keeps that output at 0.
- R7: A cycle with dt_we=1 and nonzero dt_wdata loads the dead-time register. A write of 0 is ignored. A count uses the value captured when it started, so a write during a count does not change that count.
- R8: Bit i of gate_out is driven only by bit i of gate_in (phase p uses bits 2p and 2p+1). The channels count independently.
- R9: Only edges where cnt_tick is 1 advance a count. Edges without a tick leave the remaining time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dt_we | input | 1 | Dead-time register write strobe |
| dt_wdata | input | 8 | Dead-time value to write (1..255; 0 is ignored) |
| cnt_tick | input | 1 | Count-source enable from the prescaler |
| trig_sel | input | 1 | Start trigger: 0 = input edge, 1 = external pulse |
| ext_trig | input | 1 | External start trigger pulse |
| dt_off | input | 1 | 1 bypasses the dead-time delay |
| gate_in | input | 6 | Raw gate signals, active low |
| gate_out | output | 6 | Corrected gate signals, active low |

## Verification
The main delay path is driven with several dead-time values, including 1 and 255, and with ticks every cycle or every third cycle. This separates a counter that counts ticks from one that counts clocks, and an off-by-one at either end of the range. A fall that is withdrawn before the count ends, and a write during a count, separate true cancellation and start-time capture from a counter that keeps running or reads the register live. Staggered falls on two channels, the external-trigger mode held without a pulse, and bypass patterns show that channels are independent, that arming alone never releases an output, and that bypass is a true pass-through.

// File: rtl/dtins_pkg.sv
package dtins_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_WAIT  = 2'd1,
      CH_COUNT = 2'd2
   } ch_state_e;

   localparam logic GATE_ON  = 1'b0;
   localparam logic GATE_OFF = 1'b1;
endpackage

// File: rtl/dtins_dtreg.sv
module dtins_dtreg #(
   parameter int DT_W     = 8,
   parameter int DT_RESET = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [DT_W-1:0] wdata_i,
   output logic [DT_W-1:0] dt_o
);
   localparam logic [DT_W-1:0] RST_VAL = DT_W'(DT_RESET);

   logic [DT_W-1:0] dt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dt_q <= RST_VAL;
      end else if (we_i && (wdata_i != '0)) begin
         dt_q <= wdata_i;
      end
   end

   assign dt_o = dt_q;

   // R7
   zero_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wdata_i == '0) |=> $stable(dt_q));

   // R7
   nonzero_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wdata_i != '0) |=> (dt_q == $past(wdata_i)));
endmodule

// File: rtl/dtins_chan.sv
module dtins_chan
   import dtins_pkg::*;
#(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            gate_i,
   input  logic            tick_i,
   input  logic            trig_sel_i,
   input  logic            ext_trig_i,
   input  logic            bypass_i,
   input  logic [DT_W-1:0] dt_i,
   output logic            gate_o
);
   localparam logic [DT_W-1:0] ONE = DT_W'(1);

   ch_state_e       st;
   logic [DT_W-1:0] cnt;
   logic            in_q;
   logic            hold_q;
   logic            fall;

   assign fall = (in_q == GATE_OFF) && (gate_i == GATE_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= GATE_OFF;
         st     <= CH_IDLE;
         cnt    <= '0;
         hold_q <= GATE_OFF;
      end else begin
         in_q <= gate_i;
         if (bypass_i) begin
            st     <= CH_IDLE;
            cnt    <= '0;
            hold_q <= gate_i;
         end else if (gate_i == GATE_OFF) begin
            st     <= CH_IDLE;
            cnt    <= '0;
            hold_q <= GATE_OFF;
         end else begin
            unique case (st)
               CH_IDLE: begin
                  if (fall) begin
                     if (trig_sel_i) begin
                        st <= CH_WAIT;
                     end else begin
                        st  <= CH_COUNT;
                        cnt <= dt_i;
                     end
                  end
               end
               CH_WAIT: begin
                  if (ext_trig_i) begin
                     st  <= CH_COUNT;
                     cnt <= dt_i;
                  end
               end
               CH_COUNT: begin
                  if (tick_i) begin
                     if (cnt == ONE) begin
                        st     <= CH_IDLE;
                        cnt    <= '0;
                        hold_q <= GATE_ON;
                     end else begin
                        cnt <= cnt - ONE;
                     end
                  end
               end
               default: begin
                  st  <= CH_IDLE;
                  cnt <= '0;
               end
            endcase
         end
      end
   end

   assign gate_o = bypass_i ? gate_i : (gate_i | hold_q);

   // R2
   cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_COUNT) |-> (cnt != '0));

   // R2
   release_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hold_q) && !$past(bypass_i)) |->
         $past(st == CH_COUNT && tick_i && cnt == ONE));

   // R4
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != CH_IDLE && gate_i == GATE_OFF && !bypass_i) |=>
         (st == CH_IDLE && hold_q == GATE_OFF));

   // R5
   wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_WAIT && !ext_trig_i && gate_i == GATE_ON && !bypass_i) |=>
         (st == CH_WAIT && hold_q == GATE_OFF));

   // R6
   bypass_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_i |=> (hold_q == $past(gate_i)));

   // R9
   no_tick_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_COUNT && !tick_i && gate_i == GATE_ON && !bypass_i) |=>
         (st == CH_COUNT && $stable(cnt)));
endmodule

// File: rtl/dead_time_inserter.sv
module dead_time_inserter #(
   parameter int NUM_PHASES = 3,
   parameter int DT_W       = 8,
   parameter int DT_RESET   = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dt_we,
   input  logic [DT_W-1:0]         dt_wdata,
   input  logic                    cnt_tick,
   input  logic                    trig_sel,
   input  logic                    ext_trig,
   input  logic                    dt_off,
   input  logic [2*NUM_PHASES-1:0] gate_in,
   output logic [2*NUM_PHASES-1:0] gate_out
);
   localparam int NCH    = 2 * NUM_PHASES;
   localparam int DT_MAX = (1 << DT_W) - 1;

   if (NUM_PHASES < 1) begin : g_bad_phases
      $error("dead_time_inserter: NUM_PHASES must be at least 1");
   end
   if (DT_W < 2 || DT_W > 16) begin : g_bad_width
      $error("dead_time_inserter: DT_W must be within 2..16");
   end
   if (DT_RESET < 1 || DT_RESET > DT_MAX) begin : g_bad_reset
      $error("dead_time_inserter: DT_RESET must be within 1..2**DT_W-1");
   end

   logic [DT_W-1:0] dt_val;

   dtins_dtreg #(
      .DT_W     (DT_W),
      .DT_RESET (DT_RESET)
   ) u_dtreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (dt_we),
      .wdata_i (dt_wdata),
      .dt_o    (dt_val)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dtins_chan #(
         .DT_W (DT_W)
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .gate_i     (gate_in[i]),
         .tick_i     (cnt_tick),
         .trig_sel_i (trig_sel),
         .ext_trig_i (ext_trig),
         .bypass_i   (dt_off),
         .dt_i       (dt_val),
         .gate_o     (gate_out[i])
      );
   end

   // R3
   inactive_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_in == {NCH{1'b1}}) |=> ##0 ((gate_out | ~gate_in) == {NCH{1'b1}}));
endmodule

// File: tb/dead_time_inserter_bench.sv
module dead_time_inserter_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dt_we = 1'b0;
   logic [7:0] dt_wdata = 8'd0;
   logic       cnt_tick = 1'b0;
   logic       trig_sel = 1'b0;
   logic       ext_trig = 1'b0;
   logic       dt_off = 1'b0;
   logic [5:0] gate_in = 6'h00;
   logic [5:0] gate_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dead_time_inserter u_dead_time_inserter (
      .clk      (clk),
      .rst_n    (rst_n),
      .dt_we    (dt_we),
      .dt_wdata (dt_wdata),
      .cnt_tick (cnt_tick),
      .trig_sel (trig_sel),
      .ext_trig (ext_trig),
      .dt_off   (dt_off),
      .gate_in  (gate_in),
      .gate_out (gate_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_dt(input logic [7:0] v);
      @(negedge clk);
      dt_we = 1'b1;
      dt_wdata = v;
      @(negedge clk);
      dt_we = 1'b0;
   endtask

   // Drops channel ch, ticks every 'period' cycles, expects release after n ticks.
   task automatic check_delay(input string req, input int ch, input int n, input int period);
      int ticks = 0;
      int lat = 0;
      bit bad = 0;
      int badv = 0;
      @(negedge clk);
      gate_in[ch] = 1'b0;
      cnt_tick = 1'b0;
      @(posedge clk);
      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         cnt_tick = ((i % period) == period - 1);
         @(posedge clk);
         if (cnt_tick) ticks++;
         #1;
         lat++;
         if (!bad && gate_out[ch] !== ((ticks >= n) ? 1'b0 : 1'b1)) begin
            bad = 1;
            badv = lat;
         end
         if (ticks >= n) break;
      end
      chk(!bad, req, badv, n * period);
      chk(lat == n * period && gate_out[ch] == 1'b0, req, lat, n * period);
      chk((gate_out | (6'h01 << ch)) == 6'h3F, "R8", gate_out, 6'h3F);
      @(negedge clk);
      cnt_tick = 1'b0;
      gate_in[ch] = 1'b1;
      #1;
      chk(gate_out[ch] == 1'b1, "R3", gate_out[ch], 1);
   endtask

   task automatic t_reset;
      gate_in = 6'h00;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk(gate_out == 6'h3F, "R1", gate_out, 6'h3F);
      @(negedge clk);
      gate_in = 6'h3F;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(gate_out == 6'h3F, "R1", gate_out, 6'h3F);
      check_delay("R1", 0, 1, 1);
   endtask

   task automatic t_delays;
      write_dt(8'd4);
      check_delay("R2", 1, 4, 1);
      write_dt(8'd3);
      check_delay("R9", 2, 3, 3);
      write_dt(8'd255);
      check_delay("R2", 3, 255, 1);
      write_dt(8'd1);
      check_delay("R2", 5, 1, 2);
   endtask

   task automatic t_cancel;
      bit bad = 0;
      write_dt(8'd5);
      @(negedge clk);
      gate_in[1] = 1'b0;
      cnt_tick = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      gate_in[1] = 1'b1;
      #1;
      chk(gate_out[1] == 1'b1, "R3", gate_out[1], 1);
      for (int i = 0; i < 10; i++) begin
         @(posedge clk);
         #1;
         if (gate_out[1] != 1'b1) bad = 1;
      end
      chk(!bad, "R4", gate_out[1], 1);
      @(negedge clk);
      cnt_tick = 1'b0;
      check_delay("R4", 1, 5, 1);
   endtask

   task automatic t_ext_trigger;
      bit bad = 0;
      write_dt(8'd3);
      @(negedge clk);
      trig_sel = 1'b1;
      cnt_tick = 1'b1;
      gate_in[2] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(posedge clk);
         #1;
         if (gate_out[2] != 1'b1) bad = 1;
      end
      chk(!bad, "R5", gate_out[2], 1);
      @(negedge clk);
      ext_trig = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ext_trig = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1;
      chk(gate_out[2] == 1'b1, "R5", gate_out[2], 1);
      @(posedge clk);
      #1;
      chk(gate_out[2] == 1'b0, "R5", gate_out[2], 0);
      @(negedge clk);
      gate_in[2] = 1'b1;
      cnt_tick = 1'b0;
      trig_sel = 1'b0;
   endtask

   task automatic t_bypass;
      @(negedge clk);
      dt_off = 1'b1;
      gate_in = 6'b101010;
      #1;
      chk(gate_out == 6'b101010, "R6", gate_out, 6'b101010);
      @(negedge clk);
      gate_in = 6'b010100;
      #1;
      chk(gate_out == 6'b010100, "R6", gate_out, 6'b010100);
      @(negedge clk);
      dt_off = 1'b0;
      @(posedge clk);
      #1;
      chk(gate_out == 6'b010100, "R6", gate_out, 6'b010100);
      @(negedge clk);
      gate_in = 6'h3F;
      #1;
      chk(gate_out == 6'h3F, "R3", gate_out, 6'h3F);
   endtask

   task automatic t_register;
      bit bad = 0;
      write_dt(8'd6);
      @(negedge clk);
      gate_in[4] = 1'b0;
      cnt_tick = 1'b0;
      @(posedge clk);
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         cnt_tick = 1'b1;
         dt_we = (i == 3);
         dt_wdata = 8'd2;
         @(posedge clk);
         #1;
         if (gate_out[4] != ((i < 6) ? 1'b1 : 1'b0)) bad = 1;
      end
      chk(!bad, "R7", gate_out[4], 0);
      @(negedge clk);
      dt_we = 1'b0;
      cnt_tick = 1'b0;
      gate_in[4] = 1'b1;
      check_delay("R7", 4, 2, 1);
      write_dt(8'd0);
      check_delay("R7", 0, 2, 1);
   endtask

   task automatic t_independent;
      write_dt(8'd4);
      @(negedge clk);
      cnt_tick = 1'b1;
      gate_in[0] = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      gate_in[5] = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(posedge clk);
      #1;
      chk(gate_out[0] == 1'b0 && gate_out[5] == 1'b1, "R8", gate_out, 6'b111110);
      @(posedge clk);
      #1;
      chk(gate_out[5] == 1'b1, "R8", gate_out[5], 1);
      @(posedge clk);
      #1;
      chk(gate_out == 6'b011110, "R8", gate_out, 6'b011110);
      @(negedge clk);
      cnt_tick = 1'b0;
      gate_in = 6'h3F;
      #1;
      chk(gate_out == 6'h3F, "R3", gate_out, 6'h3F);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_delays();
      t_cancel();
      t_ext_trigger();
      t_bypass();
      t_register();
      t_independent();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule